// File: doc/BRIEF.md
# Symmetric Pre-Add FIR Cell

This block is one filter cell for linear-phase FIR filtering. Input samples enter a forward chain of delay segments. A second sample stream enters a reverse chain of matching segments from the opposite end. At each of four tap positions an ALU folds the forward sample and the reverse sample into one 11-bit value. Each folded value is multiplied by the coefficient for that tap, so four multipliers serve an eight-tap symmetric filter. The spacing between taps can be set from 1 to 16 samples, which supports decimating and polyphase filters.

The four products are summed and fed to an accumulator. The accumulator either keeps adding the new sums or, when accumulate-enable is low, hands its total to an output holding register and restarts from the current sum. The ALU can add or subtract, and each ALU input can be forced to zero, which covers asymmetric and single-sided use. A shift-enable input freezes both chains so the caller can pause sample entry.

The coefficients come in on a port from a separate coefficient bank, one 10-bit lane per tap. They can change every cycle. The reverse chain takes its samples from its own input port.

Top module: `symfir_cell`

## Requirements
- R1: After reset, `hold_o` reads 0 and every delay stage holds 0.
- R2: With `dec_sel_i` = d (0 to 15), the spacing is D = d+1 shifts. Forward tap k (k = 0..3) holds the forward sample entered k·D shifts ago; tap 0 is the newest. Reverse tap k holds the reverse sample entered (3−k)·D shifts ago, so reverse tap 3 is the newest.
- R3: With `odd_sym_i` = 0 the ALU of tap k outputs b+a. With `odd_sym_i` = 1 it outputs b−a. Here a is forward tap k, b is reverse tap k, both are 10-bit two's complement, and the 11-bit result is exact.
- R4: When `fwd_n_i` is 1, the ALU operand a is 0. When `rev_n_i` is 1, the operand b is 0. Both are active-low enables.
- R5: On a clock edge with `shift_n_i` = 0, both chains advance by one, taking in `fwd_dat_i` and `rev_dat_i`. With `shift_n_i` = 1, both chains hold and the data inputs are ignored.
- R6: Coefficient lane k is `coef_i[10k+9:10k]`, two's complement. The cycle's sum is Σ ALU_k·coef_k, sign-extended into 22 bits, and it wraps on overflow without saturating.
- R7: When `acc_en_i` is 1 for a cycle, the accumulator adds that cycle's sum to its contents, and `hold_o` does not change.
- R8: When `acc_en_i` is 0 for a cycle, `hold_o` takes the accumulator's previous total, and the accumulator restarts with that cycle's sum alone.
- R9: All inputs are sampled on the rising clock edge, together with the coefficient lanes of the same cycle. The effect on `hold_o` of inputs sampled at edge n appears just after edge n+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_sel_i | input | 4 | Tap spacing minus one |
| odd_sym_i | input | 1 | 0: pre-add, 1: pre-subtract |
| shift_n_i | input | 1 | Chain shift enable, active low |
| fwd_n_i | input | 1 | Forward ALU operand enable, active low |
| rev_n_i | input | 1 | Reverse ALU operand enable, active low |
| acc_en_i | input | 1 | 1: accumulate, 0: dump to hold and restart |
| fwd_dat_i | input | 10 | Forward chain sample |
| rev_dat_i | input | 10 | Reverse chain sample |
| coef_i | input | 40 | Four 10-bit coefficient lanes, lane 0 in the low bits |
| hold_o | output | 22 | Output holding register |

## Verification
Inputs sampled at one edge pass through the ALU register, the product register and the sum register, then reach the accumulator and holding register. Their effect on `hold_o` therefore appears four edges later. The bench drives each cycle's stimulus at a falling edge. It computes the expected dump from its own model of the two sample histories, and stamps the expected value with the cycle count five rising edges ahead. The monitor pops that item at the falling edge of exactly that cycle. On the cycles in between it checks that `hold_o` stays at the last dumped value. After a spacing change, the model marks results as unchecked until 50 shifts have flushed the mixed chain contents.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
  localparam int unsigned SF_DW   = 10;  // sample width
  localparam int unsigned SF_CW   = 10;  // coefficient width
  localparam int unsigned SF_AW   = 22;  // accumulator width
  localparam int unsigned SF_NTAP = 4;   // multipliers per cell
  localparam int unsigned SF_MAXD = 16;  // longest tap spacing
endpackage

// File: rtl/symfir_dly_chain.sv
// Chain of delay segments with a tap before each segment.
// Tap 0 is the head register; tap s+1 is segment s read at depth dsel.
module symfir_dly_chain #(
  parameter int unsigned DW   = symfir_pkg::SF_DW,
  parameter int unsigned NTAP = symfir_pkg::SF_NTAP,
  parameter int unsigned MAXD = symfir_pkg::SF_MAXD
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sh_en,
  input  logic [DW-1:0]                 din,
  input  logic [$clog2(MAXD)-1:0]       dsel,
  output logic [NTAP-1:0][DW-1:0]       taps
);
  logic [DW-1:0]            head_q;
  logic [NTAP-1:0][DW-1:0]  tap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     head_q <= '0;
    else if (sh_en) head_q <= din;
  end

  assign tap_w[0] = head_q;

  for (genvar s = 0; s < NTAP - 1; s++) begin : g_seg
    logic [MAXD-1:0][DW-1:0] line_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     line_q <= '0;
      else if (sh_en) line_q <= {line_q[MAXD-2:0], tap_w[s]};
    end
    assign tap_w[s+1] = line_q[dsel];
  end

  assign taps = tap_w;

  // R5: a frozen chain keeps its head sample
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_en |=> $stable(head_q));
  // R5: an enabled shift captures the presented sample
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> head_q == $past(din));
endmodule

// File: rtl/symfir_tap.sv
// One tap lane: pre-add/subtract ALU register, then coefficient multiply.
module symfir_tap #(
  parameter int unsigned DW = symfir_pkg::SF_DW,
  parameter int unsigned CW = symfir_pkg::SF_CW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DW-1:0]                 fwd_s,
  input  logic [DW-1:0]                 rev_s,
  input  logic                          zero_a,
  input  logic                          zero_b,
  input  logic                          odd_sym,
  input  logic [CW-1:0]                 coef,
  output logic signed [DW+CW:0]         prod_o
);
  localparam int unsigned ALW = DW + 1;
  localparam int unsigned PW  = ALW + CW;

  function automatic logic signed [ALW-1:0] pre_combine(
    input logic signed [DW-1:0] a,
    input logic signed [DW-1:0] b,
    input logic za,
    input logic zb,
    input logic odd);
    logic signed [ALW-1:0] ea, eb;
    ea = za ? '0 : ALW'(a);
    eb = zb ? '0 : ALW'(b);
    return odd ? (eb - ea) : (eb + ea);
  endfunction

  logic signed [ALW-1:0] alu_q;
  logic signed [CW-1:0]  coef_d;
  logic                  alu_is_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_q  <= '0;
      coef_d <= '0;
      prod_o <= '0;
    end else begin
      alu_q  <= pre_combine($signed(fwd_s), $signed(rev_s), zero_a, zero_b, odd_sym);
      coef_d <= $signed(coef);
      prod_o <= PW'(alu_q) * PW'(coef_d);
    end
  end

  assign alu_is_zero = (alu_q == '0);

  // R4: both operands disabled leaves nothing to combine
  p_zero_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_a && zero_b) |=> alu_is_zero);
  // R6: a zero folded sample gives a zero product
  p_prod_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alu_is_zero |=> (prod_o == '0));
endmodule

// File: rtl/symfir_accum.sv
// Lane summation, accumulator with clearable feedback, output holding register.
module symfir_accum #(
  parameter int unsigned NTAP = symfir_pkg::SF_NTAP,
  parameter int unsigned PW   = symfir_pkg::SF_DW + symfir_pkg::SF_CW + 1,
  parameter int unsigned AW   = symfir_pkg::SF_AW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NTAP-1:0][PW-1:0]       prods,
  input  logic                          acc_en,
  output logic signed [AW-1:0]          hold_o
);
  function automatic logic signed [AW-1:0] lane_sum(input logic [NTAP-1:0][PW-1:0] p);
    logic signed [AW-1:0] s;
    s = '0;
    for (int k = 0; k < NTAP; k++) s = s + AW'($signed(p[k]));
    return s;
  endfunction

  logic signed [AW-1:0] sop_q, acc_q;
  logic                 ae_s;
  logic                 dump_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop_q  <= '0;
      ae_s   <= 1'b0;
      acc_q  <= '0;
      hold_o <= '0;
    end else begin
      sop_q <= lane_sum(prods);
      ae_s  <= acc_en;
      if (ae_s) begin
        acc_q <= acc_q + sop_q;
      end else begin
        acc_q  <= sop_q;
        hold_o <= acc_q;
      end
    end
  end

  assign dump_evt = !ae_s;

  // R7: accumulating leaves the holding register alone
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_evt |=> $stable(hold_o));
  // R8: a dump moves the running total into the holding register
  p_hold_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dump_evt |=> hold_o == $past(acc_q));
  // R8: a dump restarts the total from the current sum alone
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dump_evt |=> acc_q == $past(sop_q));
endmodule

// File: rtl/symfir_cell.sv
module symfir_cell #(
  parameter int unsigned DW   = symfir_pkg::SF_DW,
  parameter int unsigned CW   = symfir_pkg::SF_CW,
  parameter int unsigned AW   = symfir_pkg::SF_AW,
  parameter int unsigned NTAP = symfir_pkg::SF_NTAP,
  parameter int unsigned MAXD = symfir_pkg::SF_MAXD
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MAXD)-1:0]       dec_sel_i,
  input  logic                          odd_sym_i,
  input  logic                          shift_n_i,
  input  logic                          fwd_n_i,
  input  logic                          rev_n_i,
  input  logic                          acc_en_i,
  input  logic [DW-1:0]                 fwd_dat_i,
  input  logic [DW-1:0]                 rev_dat_i,
  input  logic [NTAP*CW-1:0]            coef_i,
  output logic [AW-1:0]                 hold_o
);
  localparam int unsigned SW = $clog2(MAXD);
  localparam int unsigned PW = DW + 1 + CW;
  localparam int unsigned AE_STAGES = 3;  // sample, ALU, product

  logic [SW-1:0]           dec_q;
  logic                    odd_q, fz_q, rz_q;
  logic [NTAP*CW-1:0]      coef_q;
  logic [AE_STAGES-1:0]    ae_pipe;
  logic                    shift_evt;

  logic [NTAP-1:0][DW-1:0] ftaps, rtaps_raw;
  logic [NTAP-1:0][PW-1:0] prods;
  logic signed [AW-1:0]    hold_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= '0;
      odd_q   <= 1'b0;
      fz_q    <= 1'b0;
      rz_q    <= 1'b0;
      coef_q  <= '0;
      ae_pipe <= '0;
    end else begin
      dec_q   <= dec_sel_i;
      odd_q   <= odd_sym_i;
      fz_q    <= fwd_n_i;
      rz_q    <= rev_n_i;
      coef_q  <= coef_i;
      ae_pipe <= {ae_pipe[AE_STAGES-2:0], acc_en_i};
    end
  end

  assign shift_evt = !shift_n_i;

  symfir_dly_chain #(.DW(DW), .NTAP(NTAP), .MAXD(MAXD)) u_fwd (
    .clk(clk), .rst_n(rst_n), .sh_en(shift_evt), .din(fwd_dat_i),
    .dsel(dec_q), .taps(ftaps));

  symfir_dly_chain #(.DW(DW), .NTAP(NTAP), .MAXD(MAXD)) u_rev (
    .clk(clk), .rst_n(rst_n), .sh_en(shift_evt), .din(rev_dat_i),
    .dsel(dec_q), .taps(rtaps_raw));

  for (genvar k = 0; k < NTAP; k++) begin : g_lane
    logic signed [PW-1:0] lane_prod;
    symfir_tap #(.DW(DW), .CW(CW)) u_tap (
      .clk(clk), .rst_n(rst_n),
      .fwd_s(ftaps[k]), .rev_s(rtaps_raw[NTAP-1-k]),
      .zero_a(fz_q), .zero_b(rz_q), .odd_sym(odd_q),
      .coef(coef_q[k*CW +: CW]), .prod_o(lane_prod));
    assign prods[k] = lane_prod;
  end

  symfir_accum #(.NTAP(NTAP), .PW(PW), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .prods(prods),
    .acc_en(ae_pipe[AE_STAGES-1]), .hold_o(hold_w));

  assign hold_o = hold_w;

  // R1: holding register leaves reset at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (hold_o == '0));
endmodule

// File: tb/symfir_cell_tb.sv
module symfir_cell_tb_top;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dec_sel_i = '0;
  logic        odd_sym_i = 1'b0, shift_n_i = 1'b1, fwd_n_i = 1'b0, rev_n_i = 1'b0;
  logic        acc_en_i = 1'b0;
  logic [9:0]  fwd_dat_i = '0, rev_dat_i = '0;
  logic [39:0] coef_i = '0;
  logic [21:0] hold_o;

  always #5 clk = ~clk;  // 100 MHz

  symfir_cell dut_i (
    .clk(clk), .rst_n(rst_n), .dec_sel_i(dec_sel_i), .odd_sym_i(odd_sym_i),
    .shift_n_i(shift_n_i), .fwd_n_i(fwd_n_i), .rev_n_i(rev_n_i),
    .acc_en_i(acc_en_i), .fwd_dat_i(fwd_dat_i), .rev_dat_i(rev_dat_i),
    .coef_i(coef_i), .hold_o(hold_o));

  typedef struct { int due; longint val; bit chk; string tag; } exp_t;
  exp_t   sbq[$];
  exp_t   cur;
  int     checks = 0, fails = 0, cyc = 0;
  int     fh[64], rh[64], cf[NT];
  longint acc_m = 0;
  bit     acc_ok = 1'b1;
  int     steady = 64, prev_dec = 0;
  longint exp_hold = 0;
  bit     exp_ok = 1'b0;
  string  exp_tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint wrap22(longint v);
    longint m;
    m = v & 64'h3F_FFFF;
    if (m[21]) m = m - 64'sh40_0000;
    return m;
  endfunction

  task automatic check(longint act, longint expv, string tag);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  // Driver: one stimulus cycle, plus the model's expected dump.
  task automatic step(int x, int y, bit shn, bit fn, bit rn, bit ae, bit odd, int dec, string tag);
    longint sop;
    int d, a, b;
    @(negedge clk);
    fwd_dat_i = 10'(x); rev_dat_i = 10'(y);
    shift_n_i = shn; fwd_n_i = fn; rev_n_i = rn; acc_en_i = ae;
    odd_sym_i = odd; dec_sel_i = 4'(dec);
    for (int k = 0; k < NT; k++) coef_i[k*10 +: 10] = 10'(cf[k]);
    if (dec != prev_dec) steady = 0;
    prev_dec = dec;
    if (!shn) begin
      for (int i = 63; i > 0; i--) begin fh[i] = fh[i-1]; rh[i] = rh[i-1]; end
      fh[0] = x; rh[0] = y;
      steady++;
    end
    d = dec + 1;
    sop = 0;
    for (int k = 0; k < NT; k++) begin
      a = fn ? 0 : fh[k*d];
      b = rn ? 0 : rh[(NT-1-k)*d];
      sop += longint'(odd ? (b - a) : (b + a)) * cf[k];
    end
    sop = wrap22(sop);
    if (ae) begin
      acc_m = wrap22(acc_m + sop);
      acc_ok = acc_ok && (steady >= 50);
    end else begin
      sbq.push_back('{cyc + 5, acc_m, acc_ok, tag});
      acc_m = sop;
      acc_ok = (steady >= 50);
    end
  endtask

  // Monitor: take due items; between them the hold value must not move (R7).
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      cur = sbq.pop_front();
      exp_hold = cur.val; exp_ok = cur.chk; exp_tag = cur.tag;
      if (exp_ok) check(longint'($signed(hold_o)), exp_hold, exp_tag);
    end else if (exp_ok) begin
      check(longint'($signed(hold_o)), exp_hold, {"R7 hold steady after ", exp_tag});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int rs10();
    return int'($urandom_range(0, 1023)) - 512;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin fh[i] = 0; rh[i] = 0; end
    cf[0] = 3; cf[1] = -5; cf[2] = 7; cf[3] = 11;
    repeat (3) @(negedge clk);
    check(longint'($signed(hold_o)), 0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(longint'($signed(hold_o)), 0, "R1 after reset");

    // R2 R9: forward impulse then reverse impulse, spacing 1, pre-add (R3)
    step(100, 0, 0, 0, 0, 0, 0, 0, "R2 R9 fwd impulse");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 R9 fwd impulse");
    step(0, -37, 0, 0, 0, 0, 0, 0, "R2 R3 rev impulse");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 R3 rev impulse");

    // R2 R3: spacing 3, pre-subtract, random streams
    cf[0] = -200; cf[1] = 123; cf[2] = 511; cf[3] = -512;
    for (int i = 0; i < 80; i++) step(rs10(), rs10(), 0, 0, 0, 0, 1, 2, "R2 R3 spacing 3 subtract");

    // R2: widest spacing 16, pre-add
    for (int i = 0; i < 110; i++) step(rs10(), rs10(), 0, 0, 0, 0, 0, 15, "R2 spacing 16");

    // R6: coefficients change every cycle (per-cycle lane pairing)
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < NT; k++) cf[k] = rs10();
      step(rs10(), rs10(), 0, 0, 0, 0, 0, 15, "R6 per-cycle coefficients");
    end

    // R4: operand zeroing in each combination, both ALU modes
    for (int i = 0; i < 12; i++) step(rs10(), rs10(), 0, 1, 0, 0, 1, 15, "R4 a zeroed");
    for (int i = 0; i < 12; i++) step(rs10(), rs10(), 0, 0, 1, 0, 1, 15, "R4 b zeroed");
    for (int i = 0; i < 12; i++) step(rs10(), rs10(), 0, 1, 1, 0, 0, 15, "R4 both zeroed");

    // R5: irregular shift enable, data presented while frozen is ignored
    for (int i = 0; i < 60; i++)
      step(rs10(), rs10(), bit'($urandom_range(0, 1)), 0, 0, 0, 0, 15, "R5 shift gating");

    // R7 R8: accumulate bursts of varied length before each dump
    for (int i = 0; i < 40; i++)
      step(rs10(), rs10(), 0, 0, 0, (i % 5) != 4, i[3], 15, "R7 R8 accumulate and dump");

    // R6: full-scale sums wrap in 22 bits, also while accumulating
    for (int k = 0; k < NT; k++) cf[k] = -512;
    for (int i = 0; i < 70; i++) step(-512, -512, 0, 0, 0, 0, 0, 0, "R6 wrap single");
    for (int i = 0; i < 12; i++) step(-512, -512, 0, 0, 0, (i % 4) != 3, 0, 0, "R6 R7 wrap accumulate");

    // flush the pipeline so every queued item is compared
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R8 drain");
    repeat (8) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule